// File: doc/BRIEF.md
# BCD calendar clock counter

This block keeps calendar time from seconds up to a three-digit year. A prescaler counts pulses of a slow tick enable and, once every `TICKS_PER_SEC` of them (32768 by default), produces a one-second strobe. The strobe advances the calendar and is also driven out as `sec_pulse` so that other logic can use it.

The calendar holds seconds, minutes, hours, a weekday, the day of the month, the month and a year. Leap years follow the Gregorian rule. Every field can be read as BCD at any time. Each field can also be loaded from BCD through a simple write strobe, but only while `ctrl_en` is high. Clearing `ctrl_en` freezes the calendar and stops the prescaler. When `ctrl_en` rises again, the prescaler counts from zero.

Top module: `cal_bcd_clock`

## Requirements
- R1: `sec_pulse` is high for exactly one cycle each time `TICKS_PER_SEC` cycles with `tick_en` high have been sampled while `ctrl_en` is high. It rises in the cycle after the final tick is sampled, which is the same cycle in which the advanced fields appear on the read ports.
- R2: While `ctrl_en` is low the prescaler is held at zero and no `sec_pulse` occurs. After `ctrl_en` rises, the first pulse needs a full `TICKS_PER_SEC` ticks.
- R3: On each second, seconds count 0 to 59 and then wrap with a carry into minutes. Minutes wrap at 60 with a carry into hours. Hours wrap at 24 with a carry into the day.
- R4: When the day rolls over, the weekday advances by one and goes from 6 back to 0. It reads as BCD 0x00 to 0x06 on `rd_wday`.
- R5: The month lengths are January 31, February 28, March 31, April 30, May 31, June 30, July 31, August 31, September 30, October 31, November 30 and December 31. February has 29 days when the full year (stored year + 1900) is divisible by 4 and is either not divisible by 100 or divisible by 400.
- R6: A day past the month's length returns to 1 and advances the month. After December the month returns to January and the year increments. The year wraps from 999 to 0.
- R7: The month reads and writes as BCD 0x01 to 0x12, with 0x01 meaning January.
- R8: `rd_year` and a year write use three BCD digits: the tens and units digits in bits [7:0] and the hundreds digit in bits [11:8].
- R9: A write loads one field from `wr_data` (BCD, bits [7:0] for every field except the year), selected by `wr_sel`: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year. The new value shows on the read port in the next cycle. The write takes effect only while `ctrl_en` is high and is ignored otherwise.
- R10: If a write and a one-second strobe fall in the same cycle, the written field takes the written value and every other field advances as usual.
- R11: After reset the time reads 00:00:00, weekday 0x00, day 0x01, month 0x01, year 0x100, and `sec_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Slow timebase tick, one cycle per tick |
| ctrl_en | input | 1 | Master enable: runs the prescaler and allows writes |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 12 | BCD write value |
| sec_pulse | output | 1 | One-second strobe |
| rd_sec | output | 8 | Seconds, BCD |
| rd_min | output | 8 | Minutes, BCD |
| rd_hour | output | 8 | Hours, BCD |
| rd_wday | output | 8 | Weekday, BCD 0 to 6 |
| rd_mday | output | 8 | Day of month, BCD |
| rd_mon | output | 8 | Month, BCD 1 to 12 |
| rd_year | output | 12 | Year, three BCD digits |

## Verification
The assertions check these rules on every cycle:
- `sec_pulse` lasts one cycle and only follows a tick sampled while enabled.
- Nothing changes, and no pulse occurs, while `ctrl_en` is low.
- Seconds wrap from 59 to 00, and the weekday wraps at midnight.
- Valid second and year writes appear on the next cycle.

Some behaviour needs known dates and an exact tick count, so only the bench's scenarios can show it. This covers the month lengths, the leap-year rule for centuries and ordinary years, year carry and the 999 wrap, the tick count between pulses and the restart after a disable. It also covers the case where a write and a strobe meet in one cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int FIELD_W = 7;
    localparam int YEAR_W  = 11;

    typedef enum logic [2:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HOUR = 3'd2,
        SEL_WDAY = 3'd3,
        SEL_MDAY = 3'd4,
        SEL_MON  = 3'd5,
        SEL_YEAR = 3'd6
    } field_sel_e;

    // Binary calendar state; month is zero-based.
    typedef struct packed {
        logic [FIELD_W-1:0] sec;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] wday;
        logic [FIELD_W-1:0] mday;
        logic [FIELD_W-1:0] mon;
        logic [YEAR_W-1:0]  year;
    } cal_time_t;

    function automatic logic [7:0] bin2bcd8(input logic [FIELD_W-1:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    function automatic logic [FIELD_W-1:0] bcd2bin8(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [11:0] year2bcd(input logic [YEAR_W-1:0] y);
        logic [YEAR_W-1:0] lo;
        logic [YEAR_W-1:0] hi;
        lo = y % 11'd100;
        hi = (y / 11'd100) % 11'd10;
        return {4'(hi), bin2bcd8(7'(lo))};
    endfunction

    function automatic logic [YEAR_W-1:0] bcd2year(input logic [11:0] b);
        return YEAR_W'(bcd2bin8(b[7:0])) + YEAR_W'(b[11:8]) * 11'd100;
    endfunction

endpackage

// File: rtl/cal_timebase.sv
module cal_timebase #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic strobe
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        strobe = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == LAST) begin
                cnt_d  = '0;
                strobe = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
    import cal_pkg::*;
(
    input  logic [FIELD_W-1:0] mon0,
    input  logic [YEAR_W-1:0]  year,
    output logic [FIELD_W-1:0] days
);
    localparam logic [11:0] EPOCH = 12'd1900;

    logic [11:0] full;
    logic        leap;

    always_comb begin
        full = 12'(year) + EPOCH;
        leap = (full % 12'd4 == 12'd0) &&
               ((full % 12'd100 != 12'd0) || (full % 12'd400 == 12'd0));
        case (mon0)
            7'd1:                      days = leap ? 7'd29 : 7'd28;
            7'd3, 7'd5, 7'd8, 7'd10:   days = 7'd30;
            default:                   days = 7'd31;
        endcase
    end
endmodule

// File: rtl/cal_bcd_clock.sv
module cal_bcd_clock
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        ctrl_en,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [11:0] wr_data,
    output logic        sec_pulse,
    output logic [7:0]  rd_sec,
    output logic [7:0]  rd_min,
    output logic [7:0]  rd_hour,
    output logic [7:0]  rd_wday,
    output logic [7:0]  rd_mday,
    output logic [7:0]  rd_mon,
    output logic [11:0] rd_year
);
    localparam logic [YEAR_W-1:0] RST_YEAR = 11'd100;

    typedef struct packed {
        cal_time_t t;
        logic      pulse;
    } clk_state_t;

    clk_state_t         st_d, st_q;
    logic               strobe;
    logic [FIELD_W-1:0] mlen;

    cal_timebase #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_en),
        .tick   (tick_en),
        .strobe (strobe)
    );

    cal_month_len u_mlen (
        .mon0 (st_q.t.mon),
        .year (st_q.t.year),
        .days (mlen)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = strobe;

        // Advance by one second.
        if (strobe) begin
            if (st_q.t.sec + 7'd1 >= 7'd60) begin
                st_d.t.sec = '0;
                if (st_q.t.min + 7'd1 >= 7'd60) begin
                    st_d.t.min = '0;
                    if (st_q.t.hour + 7'd1 >= 7'd24) begin
                        st_d.t.hour = '0;
                        st_d.t.wday = (st_q.t.wday + 7'd1 >= 7'd7) ? '0 : st_q.t.wday + 7'd1;
                        if (st_q.t.mday + 7'd1 > mlen) begin
                            st_d.t.mday = 7'd1;
                            if (st_q.t.mon + 7'd1 >= 7'd12) begin
                                st_d.t.mon  = '0;
                                st_d.t.year = (st_q.t.year + 11'd1 >= 11'd1000) ? '0
                                              : st_q.t.year + 11'd1;
                            end else begin
                                st_d.t.mon = st_q.t.mon + 7'd1;
                            end
                        end else begin
                            st_d.t.mday = st_q.t.mday + 7'd1;
                        end
                    end else begin
                        st_d.t.hour = st_q.t.hour + 7'd1;
                    end
                end else begin
                    st_d.t.min = st_q.t.min + 7'd1;
                end
            end else begin
                st_d.t.sec = st_q.t.sec + 7'd1;
            end
        end

        // Field load overrides the advanced value of the same field.
        if (ctrl_en && wr_en) begin
            case (field_sel_e'(wr_sel))
                SEL_SEC:  st_d.t.sec  = bcd2bin8(wr_data[7:0]);
                SEL_MIN:  st_d.t.min  = bcd2bin8(wr_data[7:0]);
                SEL_HOUR: st_d.t.hour = bcd2bin8(wr_data[7:0]);
                SEL_WDAY: st_d.t.wday = bcd2bin8(wr_data[7:0]);
                SEL_MDAY: st_d.t.mday = bcd2bin8(wr_data[7:0]);
                SEL_MON:  st_d.t.mon  = bcd2bin8(wr_data[7:0]) - 7'd1;
                SEL_YEAR: st_d.t.year = bcd2year(wr_data);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.t.mday <= 7'd1;
            st_q.t.year <= RST_YEAR;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_pulse = st_q.pulse;
    assign rd_sec    = bin2bcd8(st_q.t.sec);
    assign rd_min    = bin2bcd8(st_q.t.min);
    assign rd_hour   = bin2bcd8(st_q.t.hour);
    assign rd_wday   = bin2bcd8(st_q.t.wday);
    assign rd_mday   = bin2bcd8(st_q.t.mday);
    assign rd_mon    = bin2bcd8(st_q.t.mon + 7'd1);
    assign rd_year   = year2bcd(st_q.t.year);
endmodule

// File: rtl/cal_bcd_clock_chk.sv
module cal_bcd_clock_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        ctrl_en,
    input logic        wr_en,
    input logic [2:0]  wr_sel,
    input logic [11:0] wr_data,
    input logic        sec_pulse,
    input logic [7:0]  rd_sec,
    input logic [7:0]  rd_min,
    input logic [7:0]  rd_hour,
    input logic [7:0]  rd_wday,
    input logic [7:0]  rd_mday,
    input logic [7:0]  rd_mon,
    input logic [11:0] rd_year
);
    logic sec_ok, year_ok;
    assign sec_ok  = (wr_data[7:4] <= 4'd5) && (wr_data[3:0] <= 4'd9);
    assign year_ok = (wr_data[11:8] <= 4'd9) && (wr_data[7:4] <= 4'd9) && (wr_data[3:0] <= 4'd9);

    p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> !sec_pulse);

    p_pulse_from_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> $past(tick_en && ctrl_en));

    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !sec_pulse);

    p_frozen_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> ($stable(rd_sec) && $stable(rd_min) && $stable(rd_hour) &&
                      $stable(rd_wday) && $stable(rd_mday) && $stable(rd_mon) &&
                      $stable(rd_year)));

    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !$past(wr_en) && $past(rd_sec) == 8'h59) |-> rd_sec == 8'h00);

    p_wday_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !$past(wr_en) && $past(rd_wday) == 8'h06 && $past(rd_hour) == 8'h23 &&
         $past(rd_min) == 8'h59 && $past(rd_sec) == 8'h59) |-> rd_wday == 8'h00);

    p_write_sec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && wr_en && wr_sel == 3'd0 && sec_ok) |=> rd_sec == $past(wr_data[7:0]));

    p_write_year_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && wr_en && wr_sel == 3'd6 && year_ok) |=> rd_year == $past(wr_data));
endmodule

bind cal_bcd_clock cal_bcd_clock_chk u_chk (.*);

// File: tb/test_cal_bcd_clock.sv
module test_cal_bcd_clock;
    localparam int TPS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [11:0] wr_data = '0;
    logic        tick_en;
    logic        sec_pulse;
    logic [7:0]  rd_sec, rd_min, rd_hour, rd_wday, rd_mday, rd_mon;
    logic [11:0] rd_year;

    int n_cmp = 0;
    int n_bad = 0;
    int tick_mode = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    initial forever begin
        @(posedge clk);
        #1 cyc++;
    end
    assign tick_en = (tick_mode == 1) || (tick_mode == 2 && (cyc % 3) == 0);

    cal_bcd_clock #(.TICKS_PER_SEC(TPS)) i_cal_bcd_clock (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl_en(ctrl_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .sec_pulse(sec_pulse),
        .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour), .rd_wday(rd_wday),
        .rd_mday(rd_mday), .rd_mon(rd_mon), .rd_year(rd_year)
    );

    // Reference calendar (month 1..12, year 0..999).
    int m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_year;

    typedef struct {
        logic [7:0]  s, mi, h, w, d, mo;
        logic [11:0] y;
        string       tag;
    } snap_t;
    snap_t exp_q[$];

    function automatic logic [7:0] bcd2(int v);
        return 8'((v / 10) * 16 + v % 10);
    endfunction

    function automatic logic [11:0] bcd3(int v);
        return 12'((v / 100) * 256 + ((v % 100) / 10) * 16 + v % 10);
    endfunction

    function automatic int month_days(int mon, int yr);
        int full;
        bit leap;
        full = yr + 1900;
        leap = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
        case (mon)
            2:             return leap ? 29 : 28;
            4, 6, 9, 11:   return 30;
            default:       return 31;
        endcase
    endfunction

    function automatic void model_step();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0;
                    m_wday = (m_wday == 6) ? 0 : m_wday + 1;
                    if (m_mday == month_days(m_mon, m_year)) begin
                        m_mday = 1;
                        if (m_mon == 12) begin
                            m_mon = 1;
                            m_year = (m_year == 999) ? 0 : m_year + 1;
                        end else m_mon++;
                    end else m_mday++;
                end
            end
        end
    endfunction

    function automatic snap_t model_snap(string tag);
        snap_t e;
        e.s = bcd2(m_sec); e.mi = bcd2(m_min); e.h = bcd2(m_hour); e.w = bcd2(m_wday);
        e.d = bcd2(m_mday); e.mo = bcd2(m_mon); e.y = bcd3(m_year); e.tag = tag;
        return e;
    endfunction

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] expv);
        n_cmp++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, expv);
        end
    endtask

    task automatic compare_snap(snap_t e);
        check(e.tag, "sec",  32'(rd_sec),  32'(e.s));
        check(e.tag, "min",  32'(rd_min),  32'(e.mi));
        check(e.tag, "hour", 32'(rd_hour), 32'(e.h));
        check(e.tag, "wday", 32'(rd_wday), 32'(e.w));
        check(e.tag, "mday", 32'(rd_mday), 32'(e.d));
        check(e.tag, "mon",  32'(rd_mon),  32'(e.mo));
        check(e.tag, "year", 32'(rd_year), 32'(e.y));
    endtask

    task automatic check_now(string tag);
        compare_snap(model_snap(tag));
    endtask

    // Monitor: pops one expected snapshot per pulse and checks the tick interval.
    initial begin
        int since;
        snap_t e;
        since = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                since = 0;
            end else begin
                if (sec_pulse) begin
                    check("R1", "ticks between pulses", 32'(since), 32'(TPS));
                    since = 0;
                    if (exp_q.size() == 0) begin
                        check("R2", "unexpected pulse", 32'd1, 32'd0);
                    end else begin
                        e = exp_q.pop_front();
                        compare_snap(e);
                    end
                end
                if (!ctrl_en) since = 0;
                else if (tick_en) since++;
            end
        end
    end

    // Driver tasks: all input changes 1 time unit after a rising edge.
    task automatic wr(input int sel, input logic [11:0] data);
        @(posedge clk);
        #1 wr_en = 1'b1; wr_sel = 3'(sel); wr_data = data;
        @(posedge clk);
        #1 wr_en = 1'b0;
        if (ctrl_en) begin
            case (sel)
                0: m_sec  = int'(data[7:4]) * 10 + int'(data[3:0]);
                1: m_min  = int'(data[7:4]) * 10 + int'(data[3:0]);
                2: m_hour = int'(data[7:4]) * 10 + int'(data[3:0]);
                3: m_wday = int'(data[7:4]) * 10 + int'(data[3:0]);
                4: m_mday = int'(data[7:4]) * 10 + int'(data[3:0]);
                5: m_mon  = int'(data[7:4]) * 10 + int'(data[3:0]);
                6: m_year = int'(data[11:8]) * 100 + int'(data[7:4]) * 10 + int'(data[3:0]);
                default: ;
            endcase
        end
    endtask

    task automatic set_time(logic [7:0] h, logic [7:0] mi, logic [7:0] s, logic [7:0] w,
                            logic [7:0] d, logic [7:0] mo, logic [11:0] y);
        wr(6, y); wr(5, {4'h0, mo}); wr(4, {4'h0, d}); wr(3, {4'h0, w});
        wr(2, {4'h0, h}); wr(1, {4'h0, mi}); wr(0, {4'h0, s});
    endtask

    task automatic run(int n, int mode, string tag);
        for (int i = 0; i < n; i++) begin
            model_step();
            exp_q.push_back(model_snap(tag));
        end
        tick_mode = mode;
        while (exp_q.size() > 0) @(posedge clk);
        #1 tick_mode = 0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #600000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

    initial begin
        snap_t e;
        m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0; m_mday = 1; m_mon = 1; m_year = 100;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check_now("R11");
        check("R11", "pulse low", 32'(sec_pulse), 32'd0);

        // R9: write ignored while disabled.
        wr(0, 12'h045);
        wr(6, 12'h321);
        check_now("R9");

        // R2: ticks while disabled produce no pulse and no change.
        tick_mode = 1;
        repeat (40) @(posedge clk);
        #1 tick_mode = 0;
        check_now("R2");

        // R1: sparse ticks, three seconds from reset.
        ctrl_en = 1'b1;
        run(3, 2, "R1");

        // R3/R4/R6/R8: end of year with weekday wrap into a century.
        set_time(8'h23, 8'h59, 8'h58, 8'h06, 8'h31, 8'h12, 12'h199);
        check_now("R9");
        run(3, 1, "R3/R4/R6/R8");

        // R3: minute and hour carry.
        set_time(8'h10, 8'h59, 8'h59, 8'h02, 8'h15, 8'h06, 12'h123);
        run(1, 1, "R3");

        // R5: leap century year 2000.
        set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 12'h100);
        run(1, 1, "R5");
        check("R5", "feb 29 in 2000", 32'(rd_mday), 32'h29);
        wr(0, 12'h059); wr(1, 12'h059); wr(2, 12'h023);
        run(1, 1, "R5");
        check("R5", "march after feb 29", 32'(rd_mon), 32'h03);

        // R5: non-leap century year 2100.
        set_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 12'h200);
        run(1, 1, "R5");
        check("R5", "2100 has no feb 29", 32'(rd_mday), 32'h01);

        // R5: ordinary leap year 2004 and a 30-day month.
        set_time(8'h23, 8'h59, 8'h59, 8'h04, 8'h28, 8'h02, 12'h104);
        run(1, 1, "R5");
        set_time(8'h23, 8'h59, 8'h59, 8'h05, 8'h30, 8'h04, 12'h104);
        run(1, 1, "R5");
        check("R5", "may after april 30", 32'(rd_mon), 32'h05);

        // R6: year wraps from 999 to 0.
        set_time(8'h23, 8'h59, 8'h59, 8'h00, 8'h31, 8'h12, 12'h999);
        run(1, 1, "R6");
        check("R6", "year wrap", 32'(rd_year), 32'h000);

        // R7/R8: month and year readback.
        wr(5, 12'h009);
        check("R7", "month readback", 32'(rd_mon), 32'h09);
        wr(6, 12'h321);
        check("R8", "year readback", 32'(rd_year), 32'h321);

        // R2: partial count, disable, re-enable; monitor checks a full interval.
        tick_mode = 1;
        repeat (3) @(posedge clk);
        #1 ctrl_en = 1'b0; tick_mode = 0;
        @(posedge clk);
        #1 ctrl_en = 1'b1;
        run(1, 1, "R2");

        // R10: write in the strobe cycle.
        set_time(8'h07, 8'h10, 8'h59, 8'h02, 8'h11, 8'h03, 12'h150);
        @(posedge clk);
        #1 ctrl_en = 1'b0;
        model_step();
        m_sec = 30;
        e = model_snap("R10");
        exp_q.push_back(e);
        @(posedge clk);
        #1 ctrl_en = 1'b1; tick_mode = 1;
        repeat (7) @(posedge clk);
        #1 wr_en = 1'b1; wr_sel = 3'd0; wr_data = 12'h030;
        @(posedge clk);
        #1 wr_en = 1'b0; tick_mode = 0;
        while (exp_q.size() > 0) @(posedge clk);
        #1;
        check_now("R10");
        check("R10", "minute still advanced", 32'(rd_min), 32'h11);

        repeat (4) @(posedge clk);
        done = 1'b1;
        report();
    end
endmodule